// File: doc/BRIEF.md
# I2C Target with Acknowledge-Time Clock Stretching

This block is an I2C target for one 7-bit address. It watches the two bus lines through a short synchronizer and finds START, repeated START and STOP. It also shifts address and data bits in and out. Both lines are handled only as open-drain pull-down enables. The surrounding chip wires each enable to a pad that either pulls the line low or floats it.

After every byte that ends in a positive acknowledge, the target pulls SCL low. It keeps SCL low for as long as the local side needs. This works as a flow-control handshake with the local logic:

- After a written data byte, the byte is offered on `rx_data_o` with `rx_valid_o` high. The stretch ends when `ready_i` rises.
- Before each read byte, `tx_req_o` asks for data. The stretch ends only when `ready_i` and `tx_valid_i` are high together. At that moment the target takes `tx_data_i`.

The length of a stretch has no upper bound.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: While `rst_ni` is low, and after it rises with both bus lines high, `scl_oe_o`, `sda_oe_o`, `rx_valid_o` and `tx_req_o` are all 0.
- R2: After a START (SDA falling while SCL is high), the first byte carries the address in bits 7..1 and the direction in bit 0 (1 = read). If bits 7..1 equal `TGT_ADDR`, the target pulls SDA low through the ninth SCL pulse.
- R3: Bits are taken MSB first, sampled while SCL is high. The target changes its SDA drive only while SCL is low.
- R4: On an address mismatch, the target gives no acknowledge, never drives SDA or SCL, and ignores all bits until the next START or STOP.
- R5: After acknowledging a write address, the target holds SCL low with `rx_valid_o` and `tx_req_o` both 0, until `ready_i` is 1.
- R6: After a written data byte, the target acknowledges it. It then holds SCL low with `rx_valid_o` = 1, and `rx_data_o` holds the received byte and stays stable, until `ready_i` is 1.
- R7: After a read-address acknowledge, or after the controller ACKs a read byte, the target holds SCL low with `tx_req_o` = 1. The hold ends only when `ready_i` and `tx_valid_i` are both 1; `tx_data_i` is then sent MSB first.
- R8: While SCL is being held, SDA is released. The hold lasts as long as the release condition stays false, for any number of cycles.
- R9: When the controller NACKs a read byte, the target releases SDA, does not stretch, and drives nothing until a START or STOP.
- R10: A repeated START in the middle of a byte drops that byte without reporting it, and address reception starts again.
- R11: After a STOP, clock pulses that are not preceded by a START get no acknowledge and no SDA drive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL level read from the pad |
| sda_i | input | 1 | SDA level read from the pad |
| scl_oe_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| rx_data_o | output | 8 | Received data byte |
| rx_valid_o | output | 1 | `rx_data_o` holds a byte waiting for `ready_i` |
| tx_req_o | output | 1 | Target waits for the next transmit byte |
| tx_data_i | input | 8 | Next byte to transmit |
| tx_valid_i | input | 1 | `tx_data_i` is valid |
| ready_i | input | 1 | Local side is ready; ends the stretch |

## Verification
The assertions rely on the bus obeying the protocol with wide margins:

- Every SCL high and low phase lasts many block clocks, so each edge passes through the synchronizer before the next one arrives.
- SDA changes only while SCL is low, except at START and STOP.
- The controller never starts a condition while the target pulls SDA low.
- Once SCL is held, the controller keeps it released and waits.

The stimulus models a controller with phases of sixteen clocks that polls the wired-AND SCL line before each high phase. It changes SDA only after its own SCL fall has been seen.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK,
    ST_RD, ST_RD_ACK, ST_HOLD, ST_IGNORE
  } tgt_state_e;

  typedef enum logic [1:0] {HK_ADR, HK_RX, HK_TX} hold_kind_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s, sda_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s      = scl_ff[SYNC_STAGES-1];
  assign sda_s      = sda_ff[SYNC_STAGES-1];
  assign scl_o      = scl_s;
  assign scl_rise_o = scl_s & ~scl_q;
  assign scl_fall_o = ~scl_s & scl_q;
  // conditions only when SCL is high on both samples
  assign start_o    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_o     = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_shreg.sv
module i2c_tgt_shreg #(
  parameter int unsigned W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clr_i,
  input  logic                   load_i,
  input  logic [W-1:0]           load_val_i,
  input  logic                   cap_i,
  input  logic                   bit_i,
  input  logic                   adv_i,
  input  logic                   tick_i,
  output logic [W-1:0]           data_o,
  output logic [$clog2(W+1)-1:0] cnt_o,
  output logic                   full_o
);
  localparam int unsigned CW = $clog2(W+1);

  logic [W-1:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      sr_q  <= load_val_i;
      cnt_q <= '0;
    end else begin
      if (cap_i) sr_q <= {sr_q[W-2:0], bit_i};
      if (adv_i) sr_q <= {sr_q[W-2:0], 1'b1};
      if (cap_i || tick_i) cnt_q <= cnt_q + CW'(1);
    end
  end

  assign data_o = sr_q;
  assign cnt_o  = cnt_q;
  assign full_o = (cnt_q == CW'(W));

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(W)); // R3
endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0]  TGT_ADDR    = 7'h42,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe_o,
  output logic              sda_oe_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              tx_req_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              ready_i
);
  localparam int unsigned CW = $clog2(BYTE_W+1);

  tgt_state_e  state_q;
  hold_kind_e  kind_q;
  logic        ack_q, rw_q, mack_q;
  logic        scl_s, rise, fall, start, stop;
  logic [BYTE_W-1:0] sr;
  logic [CW-1:0]     cnt;
  logic        full, release_hold, cap, adv, tick, clr, load;

  i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .scl_rise_o(rise), .scl_fall_o(fall),
    .start_o(start), .stop_o(stop)
  );

  assign release_hold = (state_q == ST_HOLD) && ready_i &&
                        (kind_q != HK_TX || tx_valid_i);
  assign cap  = rise && !full && (state_q == ST_ADDR || state_q == ST_WR);
  assign tick = rise && !full && (state_q == ST_RD);
  assign adv  = fall && !full && (state_q == ST_RD) && (cnt != '0);
  assign clr  = start || (release_hold && kind_q != HK_TX);
  assign load = release_hold && kind_q == HK_TX;

  i2c_tgt_shreg #(.W(BYTE_W)) u_shreg (
    .clk_i, .rst_ni, .clr_i(clr), .load_i(load), .load_val_i(tx_data_i),
    .cap_i(cap), .bit_i(sda_i_sync_bit()), .adv_i(adv), .tick_i(tick),
    .data_o(sr), .cnt_o(cnt), .full_o(full)
  );

  // sampled SDA comes from the synchronizer's view via start/stop-free path
  function automatic logic sda_i_sync_bit();
    return sda_s_q;
  endfunction

  logic [SYNC_STAGES-1:0] sda_pipe;
  logic sda_s_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sda_pipe <= '1;
    else         sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
  end
  assign sda_s_q = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= HK_ADR;
      ack_q   <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else if (start) begin
      state_q <= ST_ADDR;
      ack_q   <= 1'b0;
    end else if (stop) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR: if (fall && full) begin
          if (sr[BYTE_W-1:1] == TGT_ADDR) begin
            ack_q   <= 1'b1;
            rw_q    <= sr[0];
            state_q <= ST_ADDR_ACK;
          end else begin
            state_q <= ST_IGNORE;
          end
        end
        ST_ADDR_ACK: if (fall) begin
          ack_q   <= 1'b0;
          kind_q  <= rw_q ? HK_TX : HK_ADR;
          state_q <= ST_HOLD;
        end
        ST_WR: if (fall && full) begin
          ack_q   <= 1'b1;
          state_q <= ST_WR_ACK;
        end
        ST_WR_ACK: if (fall) begin
          ack_q   <= 1'b0;
          kind_q  <= HK_RX;
          state_q <= ST_HOLD;
        end
        ST_HOLD: if (release_hold) state_q <= (kind_q == HK_TX) ? ST_RD : ST_WR;
        ST_RD: if (fall && full) state_q <= ST_RD_ACK;
        ST_RD_ACK: begin
          if (rise) mack_q <= ~sda_s_q;
          if (fall) begin
            kind_q  <= HK_TX;
            state_q <= mack_q ? ST_HOLD : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  assign scl_oe_o   = (state_q == ST_HOLD);
  assign sda_oe_o   = ack_q | ((state_q == ST_RD) & ~sr[BYTE_W-1]);
  assign rx_valid_o = (state_q == ST_HOLD) && (kind_q == HK_RX);
  assign tx_req_o   = (state_q == ST_HOLD) && (kind_q == HK_TX);
  assign rx_data_o  = sr;

  AST_SDA_FREE_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !sda_oe_o); // R8
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_oe_o && !ready_i) |=> scl_oe_o); // R5
  AST_TX_WAITS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_req_o && !tx_valid_i) |=> tx_req_o); // R7
  AST_RX_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && $past(rx_valid_o)) |-> $stable(rx_data_o)); // R6
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> !$past(scl_s)); // R3
endmodule

// File: tb/sim_i2c_tgt_stretch.sv
module sim_i2c_tgt_stretch;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned HALF = 16;
  // {rw, addr, data, expect_ack}
  localparam logic [16:0] VECS [6] = '{
    {1'b0, 7'h42, 8'hA5, 1'b1},
    {1'b1, 7'h42, 8'h3C, 1'b1},
    {1'b0, 7'h42, 8'h00, 1'b1},
    {1'b1, 7'h42, 8'hFF, 1'b1},
    {1'b0, 7'h13, 8'h81, 1'b0},
    {1'b1, 7'h42, 8'h81, 1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic scl_ctl = 1'b1, sda_ctl = 1'b1;
  logic scl_oe, sda_oe, rx_valid, tx_req;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic tx_valid = 1'b0, ready = 1'b0;
  logic scl_line, sda_line;
  int n_chk = 0, n_pass = 0;
  int sda_cnt = 0, scl_cnt = 0, rxv_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign scl_line = scl_ctl & ~scl_oe;
  assign sda_line = sda_ctl & ~sda_oe;

  i2c_tgt_stretch u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .tx_req_o(tx_req), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .ready_i(ready)
  );

  always @(negedge clk) begin
    if (sda_oe) sda_cnt <= sda_cnt + 1;
    if (scl_oe) scl_cnt <= scl_cnt + 1;
    if (rx_valid) rxv_cnt <= rxv_cnt + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    else n_pass++;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic r);
    sda_ctl = b;
    wait_clk(HALF);
    scl_ctl = 1'b1;
    do @(negedge clk); while (!scl_line);
    wait_clk(HALF/2);
    r = sda_line;
    wait_clk(HALF/2);
    scl_ctl = 1'b0;
    wait_clk(4);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], r);
    bit_clk(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, r);
      v[i] = r;
    end
    bit_clk(~mack, r);
  endtask

  task automatic do_start();
    sda_ctl = 1'b1; wait_clk(HALF);
    scl_ctl = 1'b1;
    do @(negedge clk); while (!scl_line);
    wait_clk(HALF);
    sda_ctl = 1'b0; wait_clk(HALF);
    scl_ctl = 1'b0; wait_clk(HALF);
  endtask

  task automatic do_stop();
    sda_ctl = 1'b0; wait_clk(HALF);
    scl_ctl = 1'b1;
    do @(negedge clk); while (!scl_line);
    wait_clk(HALF);
    sda_ctl = 1'b1; wait_clk(HALF);
  endtask

  task automatic pulse_ready();
    ready = 1'b1; wait_clk(4);
    ready = 1'b0; tx_valid = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_pass, n_chk + 1);
    $finish;
  end

  initial begin
    logic ack, r;
    logic [7:0] v;
    int snap, snap2;
    wait_clk(3);
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset flags", {rx_valid, tx_req}, 0);
    rst_ni = 1'b1;
    wait_clk(5);
    chk("R1 idle outputs", {scl_oe, sda_oe, rx_valid, tx_req}, 0);

    for (int k = 0; k < 6; k++) begin
      logic rw; logic [6:0] ad; logic [7:0] dt; logic ex;
      {rw, ad, dt, ex} = VECS[k];
      snap = scl_cnt; snap2 = sda_cnt;
      do_start();
      send_byte({ad, rw}, ack);
      chk(ex ? "R2 address ack" : "R4 mismatch no ack", ack, ex);
      wait_clk(10);
      if (!ex) begin
        send_byte(dt, ack);
        chk("R4 ignored data no ack", ack, 0);
        chk("R4 no scl hold", scl_cnt, snap);
        chk("R4 no sda drive", sda_cnt, snap2);
        do_stop();
      end else if (!rw) begin
        chk("R5 write addr stretch", {scl_oe, rx_valid, tx_req}, 3'b100);
        pulse_ready();
        send_byte(dt, ack);
        chk("R6 data ack", ack, 1);
        wait_clk(10);
        chk("R6 rx_valid in stretch", {scl_oe, rx_valid}, 2'b11);
        chk("R6 rx_data", rx_data, dt);
        chk("R8 sda released", sda_oe, 0);
        pulse_ready();
        do_stop();
      end else begin
        chk("R7 tx_req in stretch", {scl_oe, tx_req}, 2'b11);
        tx_data = dt; tx_valid = 1'b1;
        pulse_ready();
        recv_byte(1'b0, v);
        chk("R7 read byte MSB first", v, dt);
        wait_clk(10);
        chk("R9 nack releases", {scl_oe, sda_oe}, 0);
        do_stop();
      end
    end

    // long stretch, repeated START mid-byte, multi-byte read
    do_start();
    send_byte({7'h42, 1'b0}, ack);
    chk("R2 ack", ack, 1);
    snap2 = sda_cnt;
    wait_clk(2000);
    chk("R8 still holding", {scl_line, scl_oe}, 2'b01);
    chk("R8 sda free during hold", sda_cnt, snap2);
    pulse_ready();
    snap = rxv_cnt;
    bit_clk(1'b1, r); bit_clk(1'b0, r); bit_clk(1'b1, r);
    do_start();
    send_byte({7'h42, 1'b1}, ack);
    chk("R10 readdress ack", ack, 1);
    chk("R10 partial byte dropped", rxv_cnt, snap);
    wait_clk(10);
    tx_valid = 1'b0; ready = 1'b1;
    wait_clk(20);
    chk("R7 ready without valid holds", {scl_oe, tx_req}, 2'b11);
    tx_data = 8'h96; tx_valid = 1'b1;
    wait_clk(4);
    ready = 1'b0; tx_valid = 1'b0;
    recv_byte(1'b1, v);
    chk("R7 first read byte", v, 8'h96);
    wait_clk(10);
    chk("R7 stretch after controller ack", tx_req, 1);
    tx_data = 8'h5A; tx_valid = 1'b1;
    pulse_ready();
    recv_byte(1'b0, v);
    chk("R7 second read byte", v, 8'h5A);
    do_stop();

    // clocks after STOP without START
    snap2 = sda_cnt;
    send_byte({7'h42, 1'b0}, ack);
    chk("R11 no ack without start", ack, 0);
    chk("R11 no sda drive", sda_cnt, snap2);

    $display("%0d/%0d checks passed", n_pass, n_chk);
    $finish;
  end
endmodule